// File: doc/BRIEF.md
# Cipher and Hash Engine Control Register Bank

This block is the software-visible register bank that sits in front of a symmetric cipher and hash offload engine. It decodes a 32-bit control word into the fields the datapath needs: enable, algorithm, direction, key length, chaining mode, arbitrary-IV select and a data-end flag. It also stores eight key words, five IV words and five digest words, and answers word reads over a simple 32-bit register port. The cipher and hash cores, the FIFOs and any interrupt logic live in neighbouring blocks. This bank only hands them decoded fields, strobes and the stored words.

The bank tracks the engine with four states:
- `ST_OFF`: the engine is disabled.
- `ST_PRIME`: the single cycle after an enabling write made while the engine was disabled. The start pulse is high here.
- `ST_RUN`: the engine is enabled.
- `ST_FLUSH`: the single cycle after any disabling write. The FIFO flush pulse is high here.

The transitions are:
- From `ST_OFF`, an enabling write goes to `ST_PRIME` and a disabling write goes to `ST_FLUSH`.
- From `ST_PRIME`, a disabling write goes to `ST_FLUSH`; otherwise the bank moves on to `ST_RUN`.
- From `ST_RUN`, a disabling write goes to `ST_FLUSH`; any other cycle stays in `ST_RUN`.
- From `ST_FLUSH`, an enabling write goes to `ST_PRIME`, a further disabling write stays in `ST_FLUSH`, and any other cycle returns to `ST_OFF`.

At the clock edge of an enabling write made from the disabled condition, the digest words are seeded. They take either the standard hash chaining constants or a copy of the IV words.

Top module: `ce_regbank`

## Requirements
- R1: After reset the control word, key, IV and digest words read zero, and neither the start pulse nor the flush pulse is high.
- R2: Control word fields are decoded as follows, and the decoded outputs change in the cycle after the write.
  - Bit 0 is enable and bit 2 is data-end.
  - Bits 6:4 are the method: 0 AES, 1 DES, 2 triple DES, 3 SHA1, 4 MD5, 5 PRNG.
  - Bit 7 is decrypt.
  - Bits 9:8 are the AES key size: 0 for 128, 1 for 192, 2 for 256.
  - Bits 13:12 are the chaining mode: 0 ECB, 1 CBC.
  - Bit 14 is arbitrary IV.
- R3: A control write (offset 0x00) with bit 0 clear stores zero as the whole control word and raises `fifo_flush` for exactly the next cycle.
- R4: A control write with bit 0 set raises `eng_start` for exactly the next cycle only when the stored enable bit was clear before the write. Enabled-to-enabled writes give no pulse and leave the digest unchanged.
- R5: On such an enabling write with bit 14 clear, digest words 0 to 3 load 67452301, EFCDAB89, 98BADCFE and 10325476 (hex). Word 4 loads C3D2E1F0, except when the written method is MD5, in which case word 4 keeps its value.
- R6: On such an enabling write with bit 14 set, each digest word is copied from the IV word with the same index.
- R7: When the written method is SHA1 or MD5, bit 2 is stored as 0. For every other method, bit 2 is stored as written.
- R8: Key words are written and read at 0x04 + 4k (k from 0 to 7), and IV words at 0x24 + 4k (k from 0 to 4). Digest words read at 0x4C + 4k (k from 0 to 4). Writes to the digest offsets have no effect.
- R9: A read of 0x44 returns (32 − `rx_used`) in bits 31:24, `tx_used` in bits 23:16, and zero elsewhere. A read of 0x48 returns zero.
- R10: A write to 0x200 raises `rx_push` in the same cycle only while the stored enable bit is set. A read of 0x200 returns `rx_head` and raises neither `rx_push` nor `tx_pop`.
- R11: A read of 0x204 returns `tx_head` and raises `tx_pop` in the same cycle when `tx_used` is nonzero. Otherwise it returns zero with no pop.
- R12: Reads of unmapped or non-word-aligned offsets return zero, and writes to them change no stored state.
- R13: `dig_upd_en` loads `dig_upd_data` into the digest words at the next edge. An enabling write that seeds the digest in the same cycle takes priority over the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the read cycle |
| rx_used | input | 6 | Words held in the input FIFO |
| tx_used | input | 6 | Words held in the output FIFO |
| rx_head | input | 32 | Word at the input FIFO head |
| tx_head | input | 32 | Word at the output FIFO head |
| dig_upd_en | input | 1 | Hash core digest update strobe |
| dig_upd_data | input | 160 | New digest words, word 0 in the low bits |
| eng_enable | output | 1 | Stored enable bit |
| eng_method | output | 3 | Stored method field |
| eng_decrypt | output | 1 | Stored direction bit |
| eng_key_size | output | 2 | Stored AES key size field |
| eng_chain | output | 2 | Stored chaining mode field |
| eng_arb_iv | output | 1 | Stored arbitrary IV bit |
| eng_data_end | output | 1 | Stored data-end bit |
| eng_start | output | 1 | One-cycle pulse after enabling from disabled |
| fifo_flush | output | 1 | One-cycle pulse after a disabling write |
| rx_push | output | 1 | Input FIFO push strobe |
| tx_pop | output | 1 | Output FIFO pop strobe |
| key_words | output | 256 | Stored key words, word 0 in the low bits |
| iv_words | output | 160 | Stored IV words, word 0 in the low bits |
| dig_words | output | 160 | Stored digest words, word 0 in the low bits |

## Verification
The assertions assume the following about the inputs:
- A control write is a single-cycle strobe.
- `tx_used` never exceeds the output FIFO depth.
- The hash core does not depend on its update landing in the same cycle as an enabling write.

The stimulus drives exactly one register access per cycle and changes inputs only on falling edges. It holds the FIFO level inputs at legal values. It overlaps a digest update with an enabling write once, deliberately, to exercise the priority rule.

// File: rtl/ce_pkg.sv
package ce_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 12;

    localparam int BIT_EN     = 0;
    localparam int BIT_DEND   = 2;
    localparam int METHOD_LSB = 4;
    localparam int BIT_DIR    = 7;
    localparam int KSZ_LSB    = 8;
    localparam int CHAIN_LSB  = 12;
    localparam int BIT_ARB    = 14;

    localparam logic [2:0] MTH_SHA1 = 3'd3;
    localparam logic [2:0] MTH_MD5  = 3'd4;

    localparam logic [ADDR_W-1:0] OFF_CTL   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_KEY0  = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_IV0   = 12'h024;
    localparam logic [ADDR_W-1:0] OFF_FSTAT = 12'h044;
    localparam logic [ADDR_W-1:0] OFF_ISTAT = 12'h048;
    localparam logic [ADDR_W-1:0] OFF_DIG0  = 12'h04C;
    localparam logic [ADDR_W-1:0] OFF_RXF   = 12'h200;
    localparam logic [ADDR_W-1:0] OFF_TXF   = 12'h204;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2,
        ST_FLUSH = 2'd3
    } eng_state_e;

    function automatic logic [WORD_W-1:0] dig_seed(input int idx);
        case (idx)
            0:       return 32'h67452301;
            1:       return 32'hEFCDAB89;
            2:       return 32'h98BADCFE;
            3:       return 32'h10325476;
            4:       return 32'hC3D2E1F0;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/ce_ctl_fsm.sv
module ce_ctl_fsm
    import ce_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ctl_q,
    output logic              preload_en,
    output logic              enable_rise,
    output logic              fifo_flush
);
    eng_state_e        state_q, state_d;
    logic [WORD_W-1:0] ctl_d;
    logic              wr_on, wr_off, was_on, hash_wr;

    assign was_on     = ctl_q[BIT_EN];
    assign wr_on      = ctl_wr && wdata[BIT_EN];
    assign wr_off     = ctl_wr && !wdata[BIT_EN];
    assign preload_en = wr_on && !was_on;
    assign hash_wr    = (wdata[METHOD_LSB +: 3] == MTH_SHA1) ||
                        (wdata[METHOD_LSB +: 3] == MTH_MD5);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_off) begin
            ctl_d = '0;
        end else if (wr_on) begin
            ctl_d = wdata;
            if (hash_wr) ctl_d[BIT_DEND] = 1'b0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (wr_on)       state_d = ST_PRIME;
                else if (wr_off) state_d = ST_FLUSH;
            end
            ST_PRIME: begin
                if (wr_off) state_d = ST_FLUSH;
                else        state_d = ST_RUN;
            end
            ST_RUN: begin
                if (wr_off) state_d = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (wr_on)       state_d = ST_PRIME;
                else if (wr_off) state_d = ST_FLUSH;
                else             state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            ctl_q   <= '0;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_d;
        end
    end

    always_comb begin
        enable_rise = (state_q == ST_PRIME);
        fifo_flush  = (state_q == ST_FLUSH);
    end

    assert_start_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        enable_rise |-> (ctl_q[BIT_EN] && !$past(ctl_q[BIT_EN])));

    assert_flush_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> (ctl_q == '0));

    assert_pulse_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({enable_rise, fifo_flush}));

    assert_hash_dend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[BIT_EN] && ((ctl_q[METHOD_LSB +: 3] == MTH_SHA1) ||
                           (ctl_q[METHOD_LSB +: 3] == MTH_MD5))) |-> !ctl_q[BIT_DEND]);
endmodule

// File: rtl/ce_word_bank.sv
module ce_word_bank
    import ce_pkg::*;
#(
    parameter int                N_WORDS = 8,
    parameter logic [ADDR_W-1:0] BASE    = 12'h004
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [WORD_W-1:0]         wdata,
    output logic [N_WORDS*WORD_W-1:0] words
);
    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        logic              hit;
        logic [WORD_W-1:0] q;
        assign hit = wr_en && (addr == BASE + ADDR_W'(4 * g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wdata;
        end
        assign words[g*WORD_W +: WORD_W] = q;
    end

    assert_bank_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(words));
endmodule

// File: rtl/ce_digest_bank.sv
module ce_digest_bank
    import ce_pkg::*;
#(
    parameter int DIG_WORDS = 5,
    parameter int IV_WORDS  = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        preload_en,
    input  logic                        arb_iv,
    input  logic                        md5_sel,
    input  logic [IV_WORDS*WORD_W-1:0]  iv_flat,
    input  logic                        upd_en,
    input  logic [DIG_WORDS*WORD_W-1:0] upd_data,
    output logic [DIG_WORDS*WORD_W-1:0] dig_flat
);
    for (genvar g = 0; g < DIG_WORDS; g++) begin : g_word
        localparam bit KEEP_ON_MD5 = (g >= 4);
        logic [WORD_W-1:0] q;
        logic [WORD_W-1:0] ivw;
        if (g < IV_WORDS) begin : g_iv
            assign ivw = iv_flat[g*WORD_W +: WORD_W];
        end else begin : g_noiv
            assign ivw = '0;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (preload_en) begin
                if (arb_iv)                         q <= ivw;
                else if (!(KEEP_ON_MD5 && md5_sel)) q <= dig_seed(g);
            end else if (upd_en) begin
                q <= upd_data[g*WORD_W +: WORD_W];
            end
        end
        assign dig_flat[g*WORD_W +: WORD_W] = q;
    end

    assert_seed_word0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && !arb_iv) |=> (dig_flat[WORD_W-1:0] == 32'h67452301));

    assert_iv_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && arb_iv) |=> (dig_flat[WORD_W-1:0] == $past(iv_flat[WORD_W-1:0])));

    if (DIG_WORDS > 4) begin : g_md5_chk
        assert_md5_keeps_w4_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (preload_en && !arb_iv && md5_sel) |=>
                $stable(dig_flat[4*WORD_W +: WORD_W]));
    end
endmodule

// File: rtl/ce_regbank.sv
module ce_regbank
    import ce_pkg::*;
#(
    parameter int KEY_WORDS = 8,
    parameter int IV_WORDS  = 5,
    parameter int DIG_WORDS = 5,
    parameter int RX_DEPTH  = 32,
    parameter int TX_DEPTH  = 33,
    localparam int CNT_W    = $clog2(TX_DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [11:0]                 bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic [CNT_W-1:0]            rx_used,
    input  logic [CNT_W-1:0]            tx_used,
    input  logic [31:0]                 rx_head,
    input  logic [31:0]                 tx_head,
    input  logic                        dig_upd_en,
    input  logic [DIG_WORDS*32-1:0]     dig_upd_data,
    output logic                        eng_enable,
    output logic [2:0]                  eng_method,
    output logic                        eng_decrypt,
    output logic [1:0]                  eng_key_size,
    output logic [1:0]                  eng_chain,
    output logic                        eng_arb_iv,
    output logic                        eng_data_end,
    output logic                        eng_start,
    output logic                        fifo_flush,
    output logic                        rx_push,
    output logic                        tx_pop,
    output logic [KEY_WORDS*32-1:0]     key_words,
    output logic [IV_WORDS*32-1:0]      iv_words,
    output logic [DIG_WORDS*32-1:0]     dig_words
);
    logic [WORD_W-1:0] ctl_q;
    logic              ctl_wr, preload_en;
    logic [7:0]        rx_free;

    assign ctl_wr  = bus_wr && (bus_addr == OFF_CTL);
    assign rx_free = 8'(RX_DEPTH) - 8'(rx_used);

    ce_ctl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .wdata       (bus_wdata),
        .ctl_q       (ctl_q),
        .preload_en  (preload_en),
        .enable_rise (eng_start),
        .fifo_flush  (fifo_flush)
    );

    ce_word_bank #(.N_WORDS(KEY_WORDS), .BASE(OFF_KEY0)) u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .words (key_words)
    );

    ce_word_bank #(.N_WORDS(IV_WORDS), .BASE(OFF_IV0)) u_iv (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .words (iv_words)
    );

    ce_digest_bank #(.DIG_WORDS(DIG_WORDS), .IV_WORDS(IV_WORDS)) u_dig (
        .clk        (clk),
        .rst_n      (rst_n),
        .preload_en (preload_en),
        .arb_iv     (bus_wdata[BIT_ARB]),
        .md5_sel    (bus_wdata[METHOD_LSB +: 3] == MTH_MD5),
        .iv_flat    (iv_words),
        .upd_en     (dig_upd_en),
        .upd_data   (dig_upd_data),
        .dig_flat   (dig_words)
    );

    assign eng_enable   = ctl_q[BIT_EN];
    assign eng_method   = ctl_q[METHOD_LSB +: 3];
    assign eng_decrypt  = ctl_q[BIT_DIR];
    assign eng_key_size = ctl_q[KSZ_LSB +: 2];
    assign eng_chain    = ctl_q[CHAIN_LSB +: 2];
    assign eng_arb_iv   = ctl_q[BIT_ARB];
    assign eng_data_end = ctl_q[BIT_DEND];

    assign rx_push = bus_wr && (bus_addr == OFF_RXF) && eng_enable;
    assign tx_pop  = bus_rd && (bus_addr == OFF_TXF) && (tx_used != '0);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == OFF_CTL)   bus_rdata = ctl_q;
            if (bus_addr == OFF_FSTAT) bus_rdata = {rx_free, 8'(tx_used), 16'h0000};
            if (bus_addr == OFF_ISTAT) bus_rdata = '0;
            if (bus_addr == OFF_RXF)   bus_rdata = rx_head;
            if (bus_addr == OFF_TXF && tx_used != '0) bus_rdata = tx_head;
            for (int i = 0; i < KEY_WORDS; i++)
                if (bus_addr == OFF_KEY0 + ADDR_W'(4 * i)) bus_rdata = key_words[i*32 +: 32];
            for (int i = 0; i < IV_WORDS; i++)
                if (bus_addr == OFF_IV0 + ADDR_W'(4 * i)) bus_rdata = iv_words[i*32 +: 32];
            for (int i = 0; i < DIG_WORDS; i++)
                if (bus_addr == OFF_DIG0 + ADDR_W'(4 * i)) bus_rdata = dig_words[i*32 +: 32];
        end
    end

    assert_empty_tx_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_TXF && tx_used == '0) |-> (bus_rdata == '0 && !tx_pop));

    assert_push_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_RXF && $past(fifo_flush) && !eng_start) |-> !rx_push);
endmodule

// File: tb/ce_regbank_tb.sv
`timescale 1ns/1ps
module ce_regbank_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [5:0]   rx_used = '0, tx_used = '0;
    logic [31:0]  rx_head = 32'hCAFE0001, tx_head = 32'hBEEF0002;
    logic         dig_upd_en = 1'b0;
    logic [159:0] dig_upd_data = '0;
    logic         eng_enable, eng_decrypt, eng_arb_iv, eng_data_end;
    logic [2:0]   eng_method;
    logic [1:0]   eng_key_size, eng_chain;
    logic         eng_start, fifo_flush, rx_push, tx_pop;
    logic [255:0] key_words;
    logic [159:0] iv_words, dig_words;

    always #10 clk = ~clk;

    ce_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_used(rx_used), .tx_used(tx_used), .rx_head(rx_head), .tx_head(tx_head),
        .dig_upd_en(dig_upd_en), .dig_upd_data(dig_upd_data),
        .eng_enable(eng_enable), .eng_method(eng_method), .eng_decrypt(eng_decrypt),
        .eng_key_size(eng_key_size), .eng_chain(eng_chain), .eng_arb_iv(eng_arb_iv),
        .eng_data_end(eng_data_end), .eng_start(eng_start), .fifo_flush(fifo_flush),
        .rx_push(rx_push), .tx_pop(tx_pop), .key_words(key_words),
        .iv_words(iv_words), .dig_words(dig_words)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit done = 0;

    logic [31:0] m_ctl = '0;
    logic [31:0] m_key [8];
    logic [31:0] m_iv  [5];
    logic [31:0] m_dig [5];
    bit          m_rise = 0, m_flush = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model, updated on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctl = '0; m_rise = 0; m_flush = 0;
            for (int i = 0; i < 8; i++) m_key[i] = '0;
            for (int i = 0; i < 5; i++) begin m_iv[i] = '0; m_dig[i] = '0; end
        end else begin
            bit seeded;
            seeded = 0;
            m_rise = 0; m_flush = 0;
            if (bus_wr && bus_addr == 12'h000) begin
                if (!bus_wdata[0]) begin
                    m_ctl = '0; m_flush = 1;
                end else begin
                    if (!m_ctl[0]) begin
                        m_rise = 1; seeded = 1;
                        if (bus_wdata[14]) begin
                            for (int i = 0; i < 5; i++) m_dig[i] = m_iv[i];
                        end else begin
                            m_dig[0] = 32'h67452301; m_dig[1] = 32'hEFCDAB89;
                            m_dig[2] = 32'h98BADCFE; m_dig[3] = 32'h10325476;
                            if (bus_wdata[6:4] != 3'd4) m_dig[4] = 32'hC3D2E1F0;
                        end
                    end
                    m_ctl = bus_wdata;
                    if (bus_wdata[6:4] == 3'd3 || bus_wdata[6:4] == 3'd4) m_ctl[2] = 1'b0;
                end
            end
            if (bus_wr) begin
                for (int i = 0; i < 8; i++) if (bus_addr == 12'(4 + 4*i)) m_key[i] = bus_wdata;
                for (int i = 0; i < 5; i++) if (bus_addr == 12'(36 + 4*i)) m_iv[i] = bus_wdata;
            end
            if (dig_upd_en && !seeded)
                for (int i = 0; i < 5; i++) m_dig[i] = dig_upd_data[i*32 +: 32];
        end
    end

    function automatic logic [31:0] mread(input logic [11:0] a);
        if (a == 12'h000) return m_ctl;
        for (int i = 0; i < 8; i++) if (a == 12'(4 + 4*i)) return m_key[i];
        for (int i = 0; i < 5; i++) if (a == 12'(36 + 4*i)) return m_iv[i];
        for (int i = 0; i < 5; i++) if (a == 12'(76 + 4*i)) return m_dig[i];
        if (a == 12'h044) return {8'(32 - int'(rx_used)), 8'(tx_used), 16'h0};
        if (a == 12'h200) return rx_head;
        if (a == 12'h204) return (tx_used != 0) ? tx_head : 32'h0;
        return 32'h0;
    endfunction

    // Per-cycle comparison of registered outputs against the model
    always @(negedge clk) if (cmp_on) begin
        check("R2 enable",    32'(eng_enable),   32'(m_ctl[0]));
        check("R2 method",    32'(eng_method),   32'(m_ctl[6:4]));
        check("R2 decrypt",   32'(eng_decrypt),  32'(m_ctl[7]));
        check("R2 key size",  32'(eng_key_size), 32'(m_ctl[9:8]));
        check("R2 chain",     32'(eng_chain),    32'(m_ctl[13:12]));
        check("R2 arb iv",    32'(eng_arb_iv),   32'(m_ctl[14]));
        check("R7 data end",  32'(eng_data_end), 32'(m_ctl[2]));
        check("R4 start",     32'(eng_start),    32'(m_rise));
        check("R3 flush",     32'(fifo_flush),   32'(m_flush));
        for (int i = 0; i < 8; i++) check("R8 key word", key_words[i*32 +: 32], m_key[i]);
        for (int i = 0; i < 5; i++) check("R8 iv word",  iv_words[i*32 +: 32],  m_iv[i]);
        for (int i = 0; i < 5; i++) check("R5/R6/R13 digest word", dig_words[i*32 +: 32], m_dig[i]);
    end

    task automatic idle();
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; dig_upd_en = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_rd = 0; bus_wr = 1; bus_addr = a; bus_wdata = d; dig_upd_en = 0;
        #1 check("R10 rx push", 32'(rx_push), 32'((a == 12'h200) && m_ctl[0]));
    endtask

    task automatic rd(input logic [11:0] a, input string req);
        @(negedge clk);
        bus_wr = 0; bus_rd = 1; bus_addr = a; dig_upd_en = 0;
        #1 check(req, bus_rdata, mread(a));
        check("R11 tx pop", 32'(tx_pop), 32'((a == 12'h204) && (tx_used != 0)));
        check("R10 no push on read", 32'(rx_push), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        cmp_on = 1;
        @(negedge clk); rst_n = 1;
        // R1 reset state
        rd(12'h000, "R1 control reset");
        rd(12'h04C, "R1 digest reset");
        rd(12'h004, "R1 key reset");
        // R8 key and IV storage
        for (int i = 0; i < 8; i++) wr(12'(4 + 4*i), 32'h11110000 + i);
        for (int i = 0; i < 5; i++) wr(12'(36 + 4*i), 32'hA0000000 + i);
        for (int i = 0; i < 8; i++) rd(12'(4 + 4*i), "R8 key readback");
        for (int i = 0; i < 5; i++) rd(12'(36 + 4*i), "R8 iv readback");
        // R4 R5 R7 enable SHA1 with data-end set
        wr(12'h000, 32'h0000_0035);
        rd(12'h000, "R7 hash data-end cleared");
        for (int i = 0; i < 5; i++) rd(12'(76 + 4*i), "R5 sha1 seed");
        // R8 R12 digest writes ignored
        wr(12'h04C, 32'hFFFF_FFFF);
        rd(12'h04C, "R8 digest write ignored");
        // R4 enabled-to-enabled: no pulse, digest kept; R2 fields
        wr(12'h000, 32'h0000_1091);
        rd(12'h000, "R2 DES decrypt CBC");
        wr(12'h000, 32'h0000_0015);
        rd(12'h000, "R7 data-end kept for DES");
        // R13 digest update
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; dig_upd_en = 1;
        for (int i = 0; i < 5; i++) dig_upd_data[i*32 +: 32] = 32'h5500_0000 + i;
        rd(12'h05C, "R13 digest update");
        // R3 disable
        wr(12'h000, 32'h0000_7FF2);
        rd(12'h000, "R3 control cleared");
        // R5 R13 enable MD5 while an update is offered: seed wins, word 4 kept
        @(negedge clk);
        bus_rd = 0; bus_wr = 1; bus_addr = 12'h000; bus_wdata = 32'h0000_0041;
        dig_upd_en = 1;
        for (int i = 0; i < 5; i++) dig_upd_data[i*32 +: 32] = 32'h7700_0000 + i;
        idle();
        rd(12'h05C, "R5 md5 keeps word 4");
        rd(12'h04C, "R13 seed beats update");
        // R6 arbitrary IV with AES-256 ECB
        wr(12'h000, 32'h0000_0000);
        wr(12'h000, 32'h0000_4201);
        for (int i = 0; i < 5; i++) rd(12'(76 + 4*i), "R6 digest from iv");
        rd(12'h000, "R2 AES-256 arb iv");
        // R9 FIFO status and interrupt status
        @(negedge clk); rx_used = 6'd5; tx_used = 6'd3;
        rd(12'h044, "R9 fifo status");
        rd(12'h048, "R9 interrupt status");
        // R10 R11 FIFO ports
        rd(12'h200, "R10 rx head peek");
        rd(12'h204, "R11 tx pop data");
        @(negedge clk); tx_used = 6'd0;
        rd(12'h204, "R11 empty tx");
        rd(12'h044, "R9 fifo status empty tx");
        wr(12'h200, 32'h1234_5678);
        wr(12'h000, 32'h0);
        wr(12'h200, 32'h1234_5678);
        // R12 unmapped and misaligned accesses
        wr(12'h060, 32'hDEAD_BEEF);
        wr(12'h006, 32'hDEAD_BEEF);
        wr(12'h3FC, 32'hDEAD_BEEF);
        rd(12'h060, "R12 unmapped read");
        rd(12'h006, "R12 misaligned read");
        rd(12'h004, "R12 key untouched");
        // R7 PRNG keeps data-end; R4 start from disabled
        wr(12'h000, 32'h0000_0055);
        rd(12'h000, "R7 PRNG data-end kept");
        idle();
        idle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule